// File: doc/BRIEF.md
# Guest Interrupt File Access Gate

This block holds a machine-level WARL register that decides which guest interrupt files of the currently selected supervisor interrupt domain a hypervisor running in that domain may see and use. Bit 0 of the register is an accumulate flag. The bits above it form a per-guest-file enable field, where bit position j stands for guest interrupt file j. The register can be written directly, and it reads back only the positions that can be stored.

Using this register, the block filters the selected domain's internal guest pending bits into the hypervisor-visible pending view. It produces the read view and the write mask for the hypervisor guest enable register. It also decides whether the guest file number chosen for virtual supervisor CSR access is usable. Finally, it forms the one-bit external-interrupt summary for the selected domain, which feeds the cross-domain pending register that machine mode uses for scheduling.

The guest file storage itself lives outside this block. The block only gates the storage's pending and enable words. It is meant to sit next to a control bit that lets machine mode take over the supervisor external interrupt for the domain, and that bit has to be writable.

Top module: `guest_file_gate`

## Requirements
- R1: After reset, `cfg_rdata` is 0.
- R2: On a clock edge with `cfg_we` high, the register takes `cfg_wdata` with every bit above position MGEILEN cleared. Bit 0 is the accumulate flag A, and bits MGEILEN:1 are the guest-file enables. `cfg_rdata` shows the stored value and reads 0 in all higher bits.
- R3: `hgeip_view` bit j equals `int_hgeip` bit j where 1 <= j <= MGEILEN and enable bit j is 1. Every other bit of `hgeip_view` reads 0, bit 0 included.
- R4: `hgeie_wmask` has bit j set exactly where 1 <= j <= MGEILEN and enable bit j is 1. `hgeie_view` equals `int_hgeie` ANDed with that mask.
- R5: `vgein_ok` is 1 exactly when `vgein` is nonzero and the enable bit at position `vgein` is 1.
- R6: `sd_pending` is 1 whenever `seip` is 1 and either `sei_deleg` is 0 or A is 1.
- R7: The guest term of `sd_pending` is the OR-reduction of `int_hgeip & int_hgeie & mask`. When A is 1, the mask is all ones. When A is 0, the mask is the complement of the register with bit 0 forced to 0. `sd_pending` is 0 when neither the R6 term nor this guest term is set.
- R8: While `cfg_we` is low, the register holds its value whatever `cfg_wdata` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | XLEN | Register write value |
| cfg_rdata | output | XLEN | Register read value |
| int_hgeip | input | XLEN | Internal guest pending bits of the selected domain |
| int_hgeie | input | XLEN | Internal guest enable bits of the selected domain |
| seip | input | 1 | Supervisor external pending of the selected domain |
| sei_deleg | input | 1 | Supervisor external interrupt delegated to supervisor |
| vgein | input | $clog2(XLEN) | Guest file chosen for virtual supervisor access |
| hgeip_view | output | XLEN | Filtered guest pending view |
| hgeie_view | output | XLEN | Filtered guest enable read view |
| hgeie_wmask | output | XLEN | Positions of the guest enable register that accept writes |
| vgein_ok | output | 1 | Chosen guest file is accessible |
| sd_pending | output | 1 | External interrupt summary for the selected domain |

## Verification
The bench writes all-ones and values with bits set above MGEILEN. A design with a wrong writable range would then read back stray high bits or lose the top guest enable. It drives pending words with bit 0 and high bits set, which exposes a view that leaks bit 0 or unfiltered positions. It selects guest file 0 with bit 0 (A) set, so a gate that treats A as an enable would accept the selection. For the summary, it sets pending only on enabled files with A clear, so a design that forgot the complement, or let bit 0 of the register into the mask, would raise the summary wrongly. It also covers the delegated supervisor interrupt with and without A.

// File: rtl/guest_file_gate.sv
module guest_file_gate #(
  parameter int XLEN    = 64,
  parameter int MGEILEN = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [XLEN-1:0]         cfg_wdata,
  output logic [XLEN-1:0]         cfg_rdata,
  input  logic [XLEN-1:0]         int_hgeip,
  input  logic [XLEN-1:0]         int_hgeie,
  input  logic                    seip,
  input  logic                    sei_deleg,
  input  logic [$clog2(XLEN)-1:0] vgein,
  output logic [XLEN-1:0]         hgeip_view,
  output logic [XLEN-1:0]         hgeie_view,
  output logic [XLEN-1:0]         hgeie_wmask,
  output logic                    vgein_ok,
  output logic                    sd_pending
);
  localparam logic [XLEN-1:0] WMASK = {{(XLEN-MGEILEN-1){1'b0}}, {(MGEILEN+1){1'b1}}};
  localparam logic [XLEN-1:0] GMASK = WMASK & ~XLEN'(1);

  logic [XLEN-1:0] en_q;
  logic [XLEN-1:0] sum_mask;
  logic            acc;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (cfg_we) en_q <= cfg_wdata & WMASK;
  end

  assign acc         = en_q[0];
  assign cfg_rdata   = en_q;
  assign hgeie_wmask = en_q & GMASK;
  assign hgeip_view  = int_hgeip & hgeie_wmask;
  assign hgeie_view  = int_hgeie & hgeie_wmask;
  assign vgein_ok    = (vgein != '0) && en_q[vgein];
  assign sum_mask    = acc ? '1 : (~en_q & ~XLEN'(1));
  assign sd_pending  = (seip && (!sei_deleg || acc)) ||
                       (|(int_hgeip & int_hgeie & sum_mask));

  a_r2_warl_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~WMASK) == '0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  a_r3_view_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (hgeip_view & ~hgeie_wmask) == '0 && !hgeip_view[0]);
  a_r5_zero_never_ok: assert property (@(posedge clk) disable iff (!rst_n)
    vgein_ok |-> vgein != '0);
  a_r6_seip_undeleg: assert property (@(posedge clk) disable iff (!rst_n)
    (seip && !sei_deleg) |-> sd_pending);
endmodule

// File: tb/guest_file_gate_test.sv
module guest_file_gate_test;
  localparam int XLEN = 64;
  localparam int MG   = 15;
  localparam int VGW  = $clog2(XLEN);
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0, seip = 0, sei_deleg = 0;
  logic [XLEN-1:0] cfg_wdata = '0, int_hgeip = '0, int_hgeie = '0;
  logic [VGW-1:0] vgein = '0;
  logic [XLEN-1:0] cfg_rdata, hgeip_view, hgeie_view, hgeie_wmask;
  logic vgein_ok, sd_pending;
  logic [XLEN-1:0] model;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guest_file_gate #(.XLEN(XLEN), .MGEILEN(MG)) uut (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .int_hgeip, .int_hgeie,
    .seip, .sei_deleg, .vgein, .hgeip_view, .hgeie_view, .hgeie_wmask,
    .vgein_ok, .sd_pending);

  function automatic logic [XLEN-1:0] wr_mask();
    logic [XLEN-1:0] m = '0;
    for (int j = 0; j <= MG; j++) m[j] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] gate_mask(logic [XLEN-1:0] r);
    logic [XLEN-1:0] m = '0;
    for (int j = 1; j <= MG; j++) m[j] = r[j];
    return m;
  endfunction

  function automatic logic exp_ok(logic [XLEN-1:0] r, logic [VGW-1:0] v);
    return (v != 0) && (int'(v) <= MG) && r[v];
  endfunction

  function automatic logic exp_sum(logic [XLEN-1:0] r, logic s, logic d,
                                   logic [XLEN-1:0] ip, logic [XLEN-1:0] ie);
    logic [XLEN-1:0] m;
    m = r[0] ? {XLEN{1'b1}} : ~r;
    m[0] = r[0];
    return (s && (!d || r[0])) || ((ip & ie & m) != 0);
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [XLEN-1:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    model = v & wr_mask();
    #1 chk("R2", cfg_rdata, model);
  endtask

  task automatic check_comb();
    #1;
    chk("R3", hgeip_view, int_hgeip & gate_mask(model));
    chk("R4", hgeie_wmask, gate_mask(model));
    chk("R4", hgeie_view, int_hgeie & gate_mask(model));
    chk("R5", 64'(vgein_ok), 64'(exp_ok(model, vgein)));
    chk("R6/R7", 64'(sd_pending), 64'(exp_sum(model, seip, sei_deleg, int_hgeip, int_hgeie)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R1", cfg_rdata, '0);

    write_reg('1);
    vgein = '0; check_comb();
    vgein = VGW'(MG); check_comb();
    vgein = VGW'(MG + 1); check_comb();

    write_reg(64'h1);
    vgein = '0; check_comb();
    int_hgeip = 64'hFFFF_0000_0000_FFFF; int_hgeie = '1; seip = 1; sei_deleg = 1;
    check_comb();
    seip = 0; check_comb();

    write_reg(64'h0000_0000_0000_0006);
    int_hgeip = 64'h6; int_hgeie = 64'h7; seip = 1; sei_deleg = 1;
    check_comb();
    int_hgeip = 64'hF; check_comb();
    seip = 1; sei_deleg = 0; int_hgeip = 0; check_comb();

    @(negedge clk); cfg_wdata = '1; cfg_we = 0;
    @(negedge clk); #1 chk("R8", cfg_rdata, model);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0)
        write_reg({$urandom(), $urandom()});
      int_hgeip = {$urandom(), $urandom()} & wr_mask() & ~64'h1;
      int_hgeie = {$urandom(), $urandom()} & wr_mask();
      if ($urandom_range(1) == 0) int_hgeip = int_hgeip & model;
      seip = 1'($urandom()); sei_deleg = 1'($urandom());
      vgein = VGW'($urandom_range(MG + 2));
      cfg_wdata = {$urandom(), $urandom()};
      check_comb();
      @(negedge clk);
      #1 chk("R8", cfg_rdata, model);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule